// File: doc/BRIEF.md
# PRBS Link Self-Test Checker

This block is the receive-side checker of a serial link self-test. When self-test is armed, the far transmitter stops sending its normal payload and side-band bits. It sends a free-running PRBS-15 stream instead, packed 24 bits into each payload word. The checker takes the recovered 24-bit words from the link. It loads its own PRBS generator from the first word it sees, then compares every following word bit by bit against the next 24 bits of its local sequence.

Results appear on one 24-bit output in one of two views. In the mismatch-map view, each output bit flags an error on the matching payload bit for the word just received. In the count view, the low byte holds a saturating count of all mismatched bits since the checker was armed. A pass flag rises after a programmable run of error-free words and drops on any error. Nothing is reported unless the receiver is locked. The checker must be armed before the transmitter switches to its test pattern, and the transmitter must be locked before that switch.

Top module: `prbs_bist_checker`

## Requirements
- R1: The checker is armed while `bist_en_i` and `lock_i` are both high. The first valid word after arming seeds the local generator and is never flagged as an error. The seed state is word bits 23 down to 9, with bit 23 the most recent sequence bit.
- R2: With `cnt_mode_i` low, `result_o` bit k is high in the cycle after a valid word whose bit k differs from the expected bit k. A cycle without a valid word leaves an all-zero map on the next cycle.
- R3: With `cnt_mode_i` high, `result_o[7:0]` holds the total number of mismatched bits since arming and `result_o[23:8]` is zero.
- R4: The error count stops at 255 and never wraps.
- R5: `pass_o` goes high in the cycle after the PASS_RUN-th consecutive error-free compared word. It goes low in the cycle after any word with a mismatch.
- R6: While `bist_en_i` or `lock_i` is low, incoming words are ignored. On the next cycle `result_o` is zero and `pass_o` is low, and the count, the pass run and the seed are all cleared.
- R7: The expected sequence is PRBS-15, with b(n) = b(n-14) xor b(n-15). Word bit 0 is the earliest of the 24 bits. The local generator advances 24 bits per word whether or not the word had errors, so a clean word that follows an errored word compares clean.
- R8: `cnt_mode_i` only selects the view. Both the map and the count keep updating, and switching view takes effect in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_i | input | 24 | Recovered payload word |
| word_vld_i | input | 1 | Word strobe, one word per high cycle |
| lock_i | input | 1 | Receiver lock status |
| bist_en_i | input | 1 | Arms the checker |
| cnt_mode_i | input | 1 | 0: mismatch map view, 1: error count view |
| result_o | output | 24 | Mismatch map or zero-extended error count |
| pass_o | output | 1 | Error-free run reached |

## Verification
The bench builds the checker with PASS_RUN set to 6 instead of the large default. This puts the exact word on which pass rises, and its drop after an injected error, within a few dozen cycles. The 24-bit word and 8-bit counter stay at their defaults. Eleven all-bits-wrong words therefore drive the count past 255, so saturation is reached quickly. Reseeding is exercised at a sequence phase that differs from the first arming.

// File: rtl/prbs_bist_checker.sv
module prbs_bist_checker #(
  parameter int WORD_W   = 24,
  parameter int LFSR_W   = 15,
  parameter int TAP_A    = 14,
  parameter int TAP_B    = 15,
  parameter int CNT_W    = 8,
  parameter int PASS_RUN = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_vld_i,
  input  logic              lock_i,
  input  logic              bist_en_i,
  input  logic              cnt_mode_i,
  output logic [WORD_W-1:0] result_o,
  output logic              pass_o
);
  localparam int ERR_W = $clog2(WORD_W + 1);
  localparam int SUM_W = ((CNT_W > ERR_W) ? CNT_W : ERR_W) + 1;
  localparam int RUN_W = $clog2(PASS_RUN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(PASS_RUN);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(PASS_RUN - 1);

  logic              seeded_q;
  logic [LFSR_W-1:0] state_q;
  logic [WORD_W-1:0] map_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [RUN_W-1:0]  run_q;
  logic              pass_q;

  function automatic logic [LFSR_W+WORD_W-1:0] advance(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] st;
    logic [WORD_W-1:0] w;
    logic              nb;
    st = s;
    w  = '0;
    for (int k = 0; k < WORD_W; k++) begin
      nb   = st[TAP_A-1] ^ st[TAP_B-1];
      w[k] = nb;
      st   = {st[LFSR_W-2:0], nb};
    end
    return {st, w};
  endfunction

  function automatic logic [LFSR_W-1:0] seed_of(input logic [WORD_W-1:0] w);
    logic [LFSR_W-1:0] s;
    for (int i = 0; i < LFSR_W; i++) s[i] = w[WORD_W-1-i];
    return s;
  endfunction

  function automatic logic [ERR_W-1:0] ones(input logic [WORD_W-1:0] v);
    logic [ERR_W-1:0] n;
    n = '0;
    for (int i = 0; i < WORD_W; i++) n = n + ERR_W'(v[i]);
    return n;
  endfunction

  logic [LFSR_W+WORD_W-1:0] adv;
  logic [LFSR_W-1:0]        nxt_state;
  logic [WORD_W-1:0]        diff;
  logic [SUM_W-1:0]         sum;
  logic [CNT_W-1:0]         cnt_next;
  logic                     armed;

  assign armed     = bist_en_i & lock_i;
  assign adv       = advance(state_q);
  assign nxt_state = adv[LFSR_W+WORD_W-1:WORD_W];
  assign diff      = word_i ^ adv[WORD_W-1:0];
  assign sum       = SUM_W'(cnt_q) + SUM_W'(ones(diff));
  assign cnt_next  = (sum > SUM_W'(CNT_MAX)) ? CNT_MAX : sum[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !armed) begin
      seeded_q <= 1'b0;
      state_q  <= '0;
      map_q    <= '0;
      cnt_q    <= '0;
      run_q    <= '0;
      pass_q   <= 1'b0;
    end else begin
      map_q <= '0;
      if (word_vld_i) begin
        if (!seeded_q) begin
          seeded_q <= 1'b1;
          state_q  <= seed_of(word_i);
        end else begin
          state_q <= nxt_state;
          map_q   <= diff;
          cnt_q   <= cnt_next;
          if (|diff) begin
            run_q  <= '0;
            pass_q <= 1'b0;
          end else begin
            if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
            if (run_q == RUN_LAST) pass_q <= 1'b1;
          end
        end
      end
    end
  end

  assign result_o = cnt_mode_i ? WORD_W'(cnt_q) : map_q;
  assign pass_o   = pass_q;
endmodule

module prbs_bist_checker_sva #(
  parameter int WORD_W = 24,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              word_vld_i,
  input logic              lock_i,
  input logic              bist_en_i,
  input logic [WORD_W-1:0] result_o,
  input logic              pass_o,
  input logic [WORD_W-1:0] map_q,
  input logic [CNT_W-1:0]  cnt_q
);
  a_r6_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!bist_en_i || !lock_i) |=> (result_o == '0 && !pass_o));

  a_r5_error_drops_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (|map_q) |-> !pass_o);

  a_r4_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == {CNT_W{1'b1}} && bist_en_i && lock_i) |=> (cnt_q == {CNT_W{1'b1}}));

  a_r3_cnt_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_en_i && lock_i) |=> (cnt_q >= $past(cnt_q)));

  a_r2_map_clears_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld_i |=> (map_q == '0));
endmodule

bind prbs_bist_checker prbs_bist_checker_sva #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .word_vld_i(word_vld_i), .lock_i(lock_i),
  .bist_en_i(bist_en_i), .result_o(result_o), .pass_o(pass_o),
  .map_q(map_q), .cnt_q(cnt_q));

// File: tb/prbs_bist_checker_tb.sv
module prbs_bist_checker_tb;
  localparam int CLK_P = 10;
  localparam int RUN   = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] word_i = '0;
  logic        word_vld_i = 1'b0;
  logic        lock_i = 1'b0;
  logic        bist_en_i = 1'b0;
  logic        cnt_mode_i = 1'b0;
  logic [23:0] result_o;
  logic        pass_o;

  prbs_bist_checker #(.PASS_RUN(RUN)) u_dut (
    .clk(clk), .rst_n(rst_n), .word_i(word_i), .word_vld_i(word_vld_i),
    .lock_i(lock_i), .bist_en_i(bist_en_i), .cnt_mode_i(cnt_mode_i),
    .result_o(result_o), .pass_o(pass_o));

  always #(CLK_P/2) clk = ~clk;

  typedef struct { int tgt; logic [23:0] res; logic ps; string tag; } exp_t;
  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  logic [14:0] hist = 15'h4A5B;
  int   m_cnt = 0;
  int   m_run = 0;
  logic m_pass = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #(CLK_P/4);
    while (q.size() > 0 && q[0].tgt <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.tgt != cyc || result_o !== e.res || pass_o !== e.ps) begin
        errors++;
        $display("FAIL %s: result=%h exp=%h pass=%b exp=%b", e.tag, result_o, e.res, pass_o, e.ps);
      end
    end
  end

  task automatic tx_word(output logic [23:0] w);
    logic nb;
    for (int k = 0; k < 24; k++) begin
      nb   = hist[13] ^ hist[14];
      w[k] = nb;
      hist = {hist[13:0], nb};
    end
  endtask

  task automatic step(input logic en, input logic lk, input logic vld, input logic mode,
                      input logic [23:0] w, input logic [23:0] er, input logic ep, input string tag);
    exp_t e;
    @(negedge clk);
    bist_en_i = en; lock_i = lk; word_vld_i = vld; cnt_mode_i = mode; word_i = w;
    e.tgt = cyc + 1; e.res = er; e.ps = ep; e.tag = tag;
    q.push_back(e);
  endtask

  function automatic logic [23:0] view(input logic mode, input logic [23:0] mask);
    return mode ? 24'(m_cnt) : mask;
  endfunction

  task automatic disarm_model();
    m_cnt = 0; m_run = 0; m_pass = 1'b0;
  endtask

  task automatic seed(input logic mode, input string tag);
    logic [23:0] w;
    tx_word(w);
    step(1'b1, 1'b1, 1'b1, mode, w, view(mode, 24'h0), m_pass, tag);
  endtask

  task automatic send(input logic [23:0] mask, input logic mode, input string tag);
    logic [23:0] w;
    int n;
    tx_word(w);
    n = $countones(mask);
    m_cnt = (m_cnt + n > 255) ? 255 : m_cnt + n;
    if (n != 0) begin m_run = 0; m_pass = 1'b0; end
    else begin m_run++; if (m_run >= RUN) m_pass = 1'b1; end
    step(1'b1, 1'b1, 1'b1, mode, w ^ mask, view(mode, mask), m_pass, tag);
  endtask

  task automatic idle(input logic mode, input string tag);
    step(1'b1, 1'b1, 1'b0, mode, 24'h5A5A5A, view(mode, 24'h0), m_pass, tag);
  endtask

  initial begin
    logic [23:0] junk;
    repeat (3) @(negedge clk);
    checks++;
    if (result_o !== 24'h0 || pass_o !== 1'b0) begin
      errors++;
      $display("FAIL R6 reset: result=%h exp=000000 pass=%b exp=0", result_o, pass_o);
    end
    rst_n = 1'b1;

    step(1'b0, 1'b1, 1'b1, 1'b0, 24'hABCDEF, 24'h0, 1'b0, "R6 disabled word ignored");
    step(1'b0, 1'b1, 1'b1, 1'b1, 24'h123456, 24'h0, 1'b0, "R6 disabled count view");

    seed(1'b0, "R1 seed word not flagged");
    for (int i = 0; i < RUN; i++) send(24'h0, 1'b0, "R5 clean run toward pass");
    idle(1'b0, "R2 idle cycle map clear");
    send(24'h000020, 1'b0, "R2 single bit 5 flagged R5 pass drop");
    send(24'h0, 1'b0, "R7 clean after error");
    send(24'hF0000F, 1'b0, "R2 multi-bit map");
    idle(1'b1, "R3 R8 count view shows 9");
    for (int i = 0; i < 12; i++) send(24'hFFFFFF, 1'b1, "R4 saturating count");
    send(24'h0, 1'b0, "R7 clean after all-wrong words");
    idle(1'b1, "R4 count held at 255");

    step(1'b1, 1'b0, 1'b1, 1'b1, 24'hFFFFFF, 24'h0, 1'b0, "R6 lock low clears");
    disarm_model();
    step(1'b1, 1'b0, 1'b1, 1'b0, 24'h0F0F0F, 24'h0, 1'b0, "R6 unlocked word ignored");
    for (int i = 0; i < 5; i++) tx_word(junk);
    seed(1'b1, "R1 reseed at new phase");
    send(24'h0, 1'b1, "R1 clean after reseed count 0");
    send(24'h800001, 1'b1, "R3 count after reseed");
    send(24'h0, 1'b0, "R2 clean map after reseed");

    step(1'b0, 1'b1, 1'b1, 1'b1, 24'h0, 24'h0, 1'b0, "R6 bist off clears count");
    disarm_model();
    step(1'b0, 1'b1, 1'b0, 1'b0, 24'h0, 24'h0, 1'b0, "R6 bist off map");

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d expectations left, exp 0", q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule